// File: doc/BRIEF.md
# Dual-Clock FIFO with Gray-Coded Pointer Crossing

This block moves a stream of data words from one clock domain into another whose clock has no fixed phase or frequency relation to the first. The producer presents a word with a write strobe on its own clock and watches a full flag. The consumer pulls words with a read strobe on its clock and watches an empty flag. Storage is a register array with an independent write port and read port. It is used as a circular buffer, addressed by pointers that each count up by one and wrap back to zero.

Each side keeps its pointer in binary for counting and also holds a registered Gray-coded copy. Only the Gray copy crosses into the other domain. It passes through a two-flop synchronizer on every bit and is turned back into binary on arrival. Because the synchronized copy can lag by a cycle, both flags are pessimistic by one entry. The write side reports full when one slot is still free. The read side reports empty while one word is still stored. So the last word written is released only when another one follows it.

Top module: `xfifo_top`

## Requirements
- R1: Words leave the read port in exactly the order they were accepted on the write port. Both pointers start at address 0, step up by one per accepted transfer and wrap from 2^ADDR_W-1 back to 0, with no loss or duplication across many wraps.
- R2: A write strobe sampled while `full` is 1 is ignored. No word is stored, the write pointer does not move, and no unread word is overwritten.
- R3: A read strobe sampled while `empty` is 1 is ignored. The read pointer does not move and `rdData` keeps its value.
- R4: `full` is 1 exactly when the write pointer minus the synchronized read pointer is at least 2^ADDR_W-1. Starting from an empty FIFO with no reads, exactly 2^ADDR_W-1 back-to-back writes are accepted.
- R5: `empty` is 1 exactly when the synchronized write pointer minus the read pointer is at most 1. When the domains are quiet, a FIFO holding one word shows `empty`=1 and a FIFO holding two words shows `empty`=0.
- R6: Each pointer crosses domains as a registered Gray value, gray = bin ^ (bin >> 1), so at most one bit of it changes per cycle. It passes through a two-flop synchronizer per bit and is decoded with bin[i] = XOR of gray bits i and above.
- R7: `rdData` is registered. It takes the word at the read address on the `rdClk` edge that accepts a read and holds at all other times.
- R8: `wrRstN` (asynchronous, active low) clears the write pointer and its Gray copy, giving `full`=0. `rdRstN` (asynchronous, active low) clears the read pointer, its Gray copy and `rdData`, giving `empty`=1.
- R9: All flags and data stay correct with the two clocks running at unrelated periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-domain clock |
| wrRstN | input | 1 | Write-domain asynchronous reset, active low |
| wrEn | input | 1 | Write strobe, sampled on wrClk |
| wrData | input | DATA_W | Word to store |
| full | output | 1 | No write accepted while high |
| rdClk | input | 1 | Read-domain clock |
| rdRstN | input | 1 | Read-domain asynchronous reset, active low |
| rdEn | input | 1 | Read strobe, sampled on rdClk |
| rdData | output | DATA_W | Registered word last read |
| empty | output | 1 | No read accepted while high |

## Verification
A directed fill from empty with no reads shows the exact write capacity and whether writes made past it are dropped. The drain that follows shows the order of the data and that one word is held back, because the empty flag is pessimistic. Reads made while empty, and then a single extra write, show the exact threshold of the empty flag. A long seeded random run with both strobes busy and clocks of 20 ns and 14 ns wraps the pointers several times. It compares every word read with a queue model and would show corruption from the crossing, an overrun or a read of an entry that was never written.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

  // Strobes the control hands to the storage datapath.
  typedef struct packed {
    logic wrStrobe;  // store wrData at the write address
    logic rdStrobe;  // load rdData from the read address
  } memStrobe_t;

endpackage

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  // Two flops per bit, each bit on its own.
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic stage1;
    logic stage2;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1 <= 1'b0;
        stage2 <= 1'b0;
      end else begin
        stage1 <= din[b];
        stage2 <= stage1;
      end
    end
    assign dout[b] = stage2;
  end

endmodule

// File: rtl/xfifo_ctrl.sv
module xfifo_ctrl
  import xfifo_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrEn,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              rdEn,
  output memStrobe_t        strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              full,
  output logic              empty,
  output logic [ADDR_W:0]   wrGrayQ,
  output logic [ADDR_W:0]   rdGrayQ
);

  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  // ---------------- write domain ----------------
  logic [PW-1:0] wrBin, wrBinNext, wrGrayNext;
  logic [PW-1:0] rdGraySync, rdBinSync, wrFill;
  logic          wrAccept;

  assign wrAccept   = wrEn && !full;
  assign wrBinNext  = wrBin + PW'(1);
  assign wrGrayNext = wrBinNext ^ (wrBinNext >> 1);

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrBin   <= '0;
      wrGrayQ <= '0;
    end else if (wrAccept) begin
      wrBin   <= wrBinNext;
      wrGrayQ <= wrGrayNext;
    end
  end

  xfifo_sync #(.WIDTH(PW)) i_rdPtrSync (
    .clk (wrClk),
    .rstN(wrRstN),
    .din (rdGrayQ),
    .dout(rdGraySync)
  );

  always_comb begin
    for (int i = 0; i < PW; i++) rdBinSync[i] = ^(rdGraySync >> i);
  end

  // Pessimistic by one slot: full with one entry still free.
  assign wrFill = wrBin - rdBinSync;
  assign full   = (wrFill >= PW'(DEPTH - 1));

  // ---------------- read domain ----------------
  logic [PW-1:0] rdBin, rdBinNext, rdGrayNext;
  logic [PW-1:0] wrGraySync, wrBinSync, rdAvail;
  logic          rdAccept;

  assign rdAccept   = rdEn && !empty;
  assign rdBinNext  = rdBin + PW'(1);
  assign rdGrayNext = rdBinNext ^ (rdBinNext >> 1);

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdBin   <= '0;
      rdGrayQ <= '0;
    end else if (rdAccept) begin
      rdBin   <= rdBinNext;
      rdGrayQ <= rdGrayNext;
    end
  end

  xfifo_sync #(.WIDTH(PW)) i_wrPtrSync (
    .clk (rdClk),
    .rstN(rdRstN),
    .din (wrGrayQ),
    .dout(wrGraySync)
  );

  always_comb begin
    for (int i = 0; i < PW; i++) wrBinSync[i] = ^(wrGraySync >> i);
  end

  // Pessimistic by one word: empty while one word is still stored.
  assign rdAvail = wrBinSync - rdBin;
  assign empty   = (rdAvail <= PW'(1));

  // ---------------- to datapath ----------------
  assign strobe.wrStrobe = wrAccept;
  assign strobe.rdStrobe = rdAccept;
  assign wrAddr = wrBin[ADDR_W-1:0];
  assign rdAddr = rdBin[ADDR_W-1:0];

endmodule

// File: rtl/xfifo_store.sv
module xfifo_store
  import xfifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  memStrobe_t        strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobe.wrStrobe) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN)              rdData <= '0;
    else if (strobe.rdStrobe) rdData <= mem[rdAddr];
  end

endmodule

// File: rtl/xfifo_top.sv
module xfifo_top
  import xfifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              full,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              empty
);

  memStrobe_t        strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [ADDR_W:0]   wrGrayQ, rdGrayQ;

  xfifo_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .wrClk  (wrClk),
    .wrRstN (wrRstN),
    .wrEn   (wrEn),
    .rdClk  (rdClk),
    .rdRstN (rdRstN),
    .rdEn   (rdEn),
    .strobe (strobe),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .full   (full),
    .empty  (empty),
    .wrGrayQ(wrGrayQ),
    .rdGrayQ(rdGrayQ)
  );

  xfifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_store (
    .wrClk (wrClk),
    .rdClk (rdClk),
    .rdRstN(rdRstN),
    .strobe(strobe),
    .wrAddr(wrAddr),
    .rdAddr(rdAddr),
    .wrData(wrData),
    .rdData(rdData)
  );

endmodule

// File: rtl/xfifo_chk.sv
module xfifo_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input logic              wrClk,
  input logic              wrRstN,
  input logic              wrEn,
  input logic              full,
  input logic              rdClk,
  input logic              rdRstN,
  input logic              rdEn,
  input logic              empty,
  input logic [DATA_W-1:0] rdData,
  input logic [ADDR_W:0]   wrGrayQ,
  input logic [ADDR_W:0]   rdGrayQ
);

  // R2
  no_overflow_chk: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (full && wrEn) |=> $stable(wrGrayQ));

  // R3
  no_underflow_chk: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (empty && rdEn) |=> ($stable(rdGrayQ) && $stable(rdData)));

  // R6
  wr_gray_step_chk: assert property (@(posedge wrClk) disable iff (!wrRstN)
    $countones(wrGrayQ ^ $past(wrGrayQ)) <= 1);

  // R6
  rd_gray_step_chk: assert property (@(posedge rdClk) disable iff (!rdRstN)
    $countones(rdGrayQ ^ $past(rdGrayQ)) <= 1);

  // R7
  rd_data_hold_chk: assert property (@(posedge rdClk) disable iff (!rdRstN)
    !(rdEn && !empty) |=> $stable(rdData));

  // R8
  always @(posedge wrClk) begin
    if (!wrRstN) wr_reset_chk: assert (!full && wrGrayQ == '0);
  end

  // R8
  always @(posedge rdClk) begin
    if (!rdRstN) rd_reset_chk: assert (empty && rdGrayQ == '0 && rdData == '0);
  end

endmodule

bind xfifo_top xfifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_xfifo_chk (
  .wrClk  (wrClk),
  .wrRstN (wrRstN),
  .wrEn   (wrEn),
  .full   (full),
  .rdClk  (rdClk),
  .rdRstN (rdRstN),
  .rdEn   (rdEn),
  .empty  (empty),
  .rdData (rdData),
  .wrGrayQ(wrGrayQ),
  .rdGrayQ(rdGrayQ)
);

// File: tb/test_xfifo_top.sv
`timescale 1ns/1ps
module test_xfifo_top;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              wrClk = 1'b0, rdClk = 1'b0;
  logic              wrRstN = 1'b0, rdRstN = 1'b0;
  logic              wrEn = 1'b0, rdEn = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic              full, empty;

  int checks = 0;
  int failures = 0;
  logic [DATA_W-1:0] model[$];
  logic [DATA_W-1:0] lastRead = '0;
  int  seqVal = 0;
  bit  wrDone = 0;

  always #10 wrClk = ~wrClk;  // 50 MHz
  always #7  rdClk = ~rdClk;  // unrelated read clock

  xfifo_top #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_xfifo_top (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrData(wrData), .full(full),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn), .rdData(rdData), .empty(empty)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] nextWord();
    seqVal++;
    return DATA_W'(seqVal * 37 + 11);
  endfunction

  task automatic settle();
    repeat (8) @(negedge wrClk);
    repeat (8) @(negedge rdClk);
  endtask

  // One read with data check; waits for empty low first.
  task automatic readWord(input string req);
    logic [DATA_W-1:0] exp;
    int guard = 0;
    @(negedge rdClk);
    while (empty && guard < 100) begin @(negedge rdClk); guard++; end
    rdEn = 1'b1;
    exp = model.pop_front();
    @(negedge rdClk);
    rdEn = 1'b0;
    check(rdData == exp, req, rdData, exp);
    lastRead = rdData;
  endtask

  task automatic writeWord(input logic [DATA_W-1:0] v);
    @(negedge wrClk);
    wrData = v;
    wrEn = 1'b1;
    if (!full) model.push_back(v);
    @(negedge wrClk);
    wrEn = 1'b0;
  endtask

  initial begin
    #3000000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int accepted;
    int dropped;
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(negedge wrClk);
    repeat (3) @(negedge rdClk);
    // R8 reset state
    check(full == 1'b0, "R8 full after reset", full, 0);
    check(empty == 1'b1, "R8 empty after reset", empty, 1);
    check(rdData == '0, "R8 rdData after reset", rdData, 0);
    wrRstN = 1'b1;
    rdRstN = 1'b1;
    settle();

    // R4 fill from empty, R2 excess writes dropped
    accepted = 0;
    dropped = 0;
    for (int i = 0; i < DEPTH + 2; i++) begin
      @(negedge wrClk);
      wrData = nextWord();
      wrEn = 1'b1;
      if (!full) begin model.push_back(wrData); accepted++; end
      else dropped++;
    end
    @(negedge wrClk);
    wrEn = 1'b0;
    check(accepted == DEPTH - 1, "R4 accepted writes until full", accepted, DEPTH - 1);
    check(full == 1'b1, "R4 full after capacity", full, 1);
    check(dropped == 3, "R2 writes refused while full", dropped, 3);

    // R1 R2 drain in order; one word stays (R5)
    while (model.size() > 1) readWord("R1 R2 drain order");
    settle();
    check(empty == 1'b1, "R5 empty with one word stored", empty, 1);
    check(model.size() == 1, "R5 one word held", model.size(), 1);
    check(full == 1'b0, "R4 full clears after drain", full, 0);

    // R3 read while empty ignored
    @(negedge rdClk);
    rdEn = 1'b1;
    @(negedge rdClk);
    rdEn = 1'b0;
    check(rdData == lastRead, "R3 rdData holds on read while empty", rdData, lastRead);
    check(empty == 1'b1, "R3 still empty", empty, 1);

    // R5 two words release one; R7 registered data
    writeWord(nextWord());
    settle();
    check(empty == 1'b0, "R5 empty low with two words", empty, 0);
    readWord("R7 R5 held word released");
    settle();
    check(rdData == lastRead, "R7 rdData stable when idle", rdData, lastRead);

    // R1 R6 R9 random traffic across wraps
    fork
      begin
        for (int n = 0; n < 3000; n++) begin
          @(negedge wrClk);
          wrEn = ($urandom_range(0, 99) < 55);
          wrData = DATA_W'($urandom());
          if (wrEn && !full) begin
            model.push_back(wrData);
            check(model.size() <= DEPTH - 1, "R2 occupancy within capacity", model.size(), DEPTH - 1);
          end
        end
        @(negedge wrClk);
        wrEn = 1'b0;
        wrDone = 1;
      end
      begin
        bit pend = 0;
        logic [DATA_W-1:0] exp = '0;
        int tail = 0;
        while (tail < 200) begin
          @(negedge rdClk);
          if (pend) check(rdData == exp, "R1 R6 R9 random data", rdData, exp);
          pend = 0;
          rdEn = ($urandom_range(0, 99) < 50);
          if (rdEn && !empty) begin
            check(model.size() > 0, "R3 no read of unwritten entry", model.size(), 1);
            if (model.size() > 0) begin
              exp = model.pop_front();
              pend = 1;
            end
          end
          if (wrDone) tail++;
        end
        @(negedge rdClk);
        if (pend) check(rdData == exp, "R1 R6 R9 random data", rdData, exp);
        rdEn = 1'b0;
      end
    join

    settle();
    check(empty == (model.size() <= 1), "R5 final empty flag", empty, model.size() <= 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule